// File: doc/BRIEF.md
# Dual-Channel Sampling Converter Serial Front End

This block is the digital side of a two-channel converter that samples both channels at once. A convert strobe (`conv`) and a serial clock (`sck`) come from the host. Both are sampled on the local clock and edge-detected there. On a rising edge of `conv`, two parallel channel words are latched at the same instant. A frame is then shifted out on a three-state pin pair (`sdo_data` with enable `sdo_oe`). Each frame carries the pair of samples taken at the previous convert edge, channel 0 first, as two's-complement words. Each word is 14 bits, MSB first, and the two words are separated by two idle serial clocks.

Power modes are selected on the same two wires. Convert pulses that arrive with no edge on the serial clock between them are counted. Two or three such pulses put the block into nap, and four or more put it into sleep. A convert pulse that follows serial-clock activity leaves nap. A rising serial-clock edge leaves sleep. The current mode is visible on `mode`.

Top module: `dual_adc_serial_if`

## Requirements
- R1: After reset, `mode` is 0 (active) and `sdo_oe` is 0.
- R2: A `conv` rising edge seen in active mode with a count result of 1 captures `ch0_in` and `ch1_in` together and starts a frame. `sdo_oe` goes to 1 in the cycle after the edge.
- R3: A frame holds 30 bit slots, and each `sck` rising edge moves to the next slot. Slots 0 to 13 carry word 0, MSB first. Slots 14 and 15 are idle. Slots 16 to 29 carry word 1, MSB first. After the 30th rising edge, `sdo_oe` is 0.
- R4: The frame started by convert edge k carries the channel 0 and channel 1 samples captured at convert edge k-1. The first frame after reset carries zeros.
- R5: Words pass through as 14-bit two's-complement values, so the first bit of each word is its sign.
- R6: `sdo_oe` is 1 only during the 28 word slots of a live frame, and never while `mode` is nap or sleep.
- R7: A `conv` rising edge is counted as 1 when any `sck` edge occurred since the previous `conv` edge. Otherwise it is counted as the previous count plus one. A count of 2 or 3 sets `mode` to 1 (nap), ends any frame, and captures nothing.
- R8: A count of 4 or more sets `mode` to 2 (sleep) and ends any frame.
- R9: The static count holds whether `sck` stays high or low. Any `sck` edge, rising or falling, restarts it.
- R10: In nap, `sck` edges alone leave `mode` at nap. A `conv` edge with count 1 returns `mode` to active, captures the inputs, and starts a frame.
- R11: In sleep, `conv` edges capture nothing and start no frame. An `sck` rising edge sets `mode` to active with `sdo_oe` still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that samples the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| conv | input | 1 | Convert strobe; a rising edge samples both channels |
| sck | input | 1 | Serial clock; a rising edge advances the frame |
| ch0_in | input | 14 | Channel 0 result, two's complement |
| ch1_in | input | 14 | Channel 1 result, two's complement |
| sdo_data | output | 1 | Serial data value toward the pad |
| sdo_oe | output | 1 | Pad drive enable; the pin floats when 0 |
| mode | output | 2 | 0 active, 1 nap, 2 sleep |

## Verification
The hardest case to reach is a sample that should have been ignored. Such a sample comes from a convert pulse that lands in nap or sleep, and it can only be seen missing one frame later, after a wake-up sequence. The stimulus builds static bursts of random length with `sck` parked at a random level. It changes the channel inputs on every pulse and then runs a full frame. The frame has to show the sample taken before the burst and not any value presented during it.

// File: rtl/dual_adc_serial_if.sv
module dual_adc_serial_if #(
  parameter int WORD_W   = 14,
  parameter int GAP_CLKS = 2,
  parameter int CNT_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv,
  input  logic              sck,
  input  logic [WORD_W-1:0] ch0_in,
  input  logic [WORD_W-1:0] ch1_in,
  output logic              sdo_data,
  output logic              sdo_oe,
  output logic [1:0]        mode
);
  localparam int FRAME_W = 2*WORD_W + GAP_CLKS;
  localparam logic [1:0] M_ACT = 2'd0, M_NAP = 2'd1, M_SLP = 2'd2;
  localparam logic [CNT_W-1:0] NAP_MIN = CNT_W'(2);
  localparam logic [CNT_W-1:0] SLP_MIN = CNT_W'(4);

  logic conv_q, sck_q, seen;
  logic [CNT_W-1:0]   cnt, cnt_nx;
  logic [WORD_W-1:0]  s0, s1;
  logic [FRAME_W-1:0] dsh, esh;

  wire conv_rise = conv & ~conv_q;
  wire sck_rise  = sck & ~sck_q;
  wire sck_fall  = ~sck & sck_q;
  wire seen_nx   = seen | sck_rise | sck_fall;

  always_comb begin
    if (seen_nx)   cnt_nx = CNT_W'(1);
    else if (&cnt) cnt_nx = cnt;
    else           cnt_nx = cnt + 1'b1;
  end

  wire go_slp  = cnt_nx >= SLP_MIN;
  wire go_nap  = (cnt_nx >= NAP_MIN) && !go_slp;
  wire capture = conv_rise && (mode != M_SLP) && !go_nap && !go_slp;

  assign sdo_data = dsh[FRAME_W-1];
  assign sdo_oe   = esh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_q <= 1'b0;
      sck_q  <= 1'b0;
      seen   <= 1'b0;
      cnt    <= '0;
      mode   <= M_ACT;
      s0     <= '0;
      s1     <= '0;
      dsh    <= '0;
      esh    <= '0;
    end else begin
      conv_q <= conv;
      sck_q  <= sck;
      seen   <= conv_rise ? 1'b0 : seen_nx;
      if (conv_rise) cnt <= cnt_nx;

      if (sck_rise && mode == M_SLP)       mode <= M_ACT;
      else if (conv_rise && mode != M_SLP) mode <= go_slp ? M_SLP : (go_nap ? M_NAP : M_ACT);

      if (capture) begin
        s0  <= ch0_in;
        s1  <= ch1_in;
        dsh <= {s0, {GAP_CLKS{1'b0}}, s1};
        esh <= {{WORD_W{1'b1}}, {GAP_CLKS{1'b0}}, {WORD_W{1'b1}}};
      end else if (conv_rise) begin
        esh <= '0;
      end else if (sck_rise && mode == M_ACT) begin
        dsh <= {dsh[FRAME_W-2:0], 1'b0};
        esh <= {esh[FRAME_W-2:0], 1'b0};
      end
    end
  end

  // R6
  oe_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_ACT) |-> !sdo_oe);

  // R2
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (sdo_oe && sdo_data == $past(s0[WORD_W-1])));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_rise && !conv_rise) |=> ($stable(sdo_data) && $stable(sdo_oe)));

  // R10
  nap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NAP && !conv_rise) |=> (mode == M_NAP));

  // R11
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLP && !sck_rise) |=> (mode == M_SLP));
endmodule

// File: tb/dual_adc_serial_if_bench.sv
module dual_adc_serial_if_bench;
  localparam int W = 14;
  localparam int FRAME = 2*W + 2;

  logic clk = 1'b0, rst_n = 1'b0, conv = 1'b0, sck = 1'b0;
  logic [W-1:0] ch0 = '0, ch1 = '0;
  logic sdo_data, sdo_oe;
  logic [1:0] mode;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_mode = 0, m_cnt = 0;
  bit m_seen = 0, m_live = 0;
  logic [W-1:0] p0 = '0, p1 = '0, f0 = '0, f1 = '0;

  always #10 clk = ~clk;

  dual_adc_serial_if u_dual_adc_serial_if (
    .clk(clk), .rst_n(rst_n), .conv(conv), .sck(sck),
    .ch0_in(ch0), .ch1_in(ch1),
    .sdo_data(sdo_data), .sdo_oe(sdo_oe), .mode(mode));

  function automatic logic [1:0] exp_slot(int i, logic [W-1:0] a, logic [W-1:0] b);
    if (i < W)                      return {1'b1, a[W-1-i]};
    if (i >= W + 2 && i < FRAME)    return {1'b1, b[W-1-(i-W-2)]};
    return 2'b00;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk(mode == 2'(m_mode), req, int'(mode), m_mode);
    if (m_mode != 0) chk(sdo_oe == 1'b0, "R6", int'(sdo_oe), 0);
  endtask

  task automatic sck_to(logic lvl);
    if (sck != lvl) begin
      @(negedge clk) sck = lvl;
      @(negedge clk);
      m_seen = 1;
      if (lvl && m_mode == 2) begin m_mode = 0; m_live = 0; end
    end
  endtask

  task automatic do_conv(logic [W-1:0] a, logic [W-1:0] b, string req);
    @(negedge clk) begin conv = 1'b1; ch0 = a; ch1 = b; end
    @(negedge clk) conv = 1'b0;
    @(negedge clk);
    m_cnt = m_seen ? 1 : (m_cnt < 7 ? m_cnt + 1 : 7);
    m_seen = 0;
    if (m_mode != 2) begin
      if (m_cnt >= 4)      begin m_mode = 2; m_live = 0; end
      else if (m_cnt >= 2) begin m_mode = 1; m_live = 0; end
      else begin
        m_mode = 0; m_live = 1;
        f0 = p0; f1 = p1; p0 = a; p1 = b;
      end
    end
    chk_state(req);
    if (m_live) chk(sdo_oe == 1'b1, "R2", int'(sdo_oe), 1);
  endtask

  task automatic run_frame(string req);
    logic [W-1:0] g0 = '0, g1 = '0;
    sck_to(1'b0);
    for (int i = 0; i < FRAME; i++) begin
      logic [1:0] e = exp_slot(i, f0, f1);
      chk(sdo_oe == e[1], "R3", int'(sdo_oe), int'(e[1]));
      if (e[1]) chk(sdo_data == e[0], req, int'(sdo_data), int'(e[0]));
      if (i < W) g0 = {g0[W-2:0], sdo_data};
      else if (i >= W + 2) g1 = {g1[W-2:0], sdo_data};
      sck_to(1'b1);
      sck_to(1'b0);
    end
    chk(sdo_oe == 1'b0, "R3", int'(sdo_oe), 0);
    chk($signed(g0) == $signed(f0), "R5", int'($signed(g0)), int'($signed(f0)));
    chk($signed(g1) == $signed(f1), "R5", int'($signed(g1)), int'($signed(f1)));
    m_live = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode == 2'd0, "R1", int'(mode), 0);
    chk(sdo_oe == 1'b0, "R1", int'(sdo_oe), 0);

    do_conv(14'h2000, 14'h1FFF, "R2");
    run_frame("R4");
    do_conv(14'h0155, 14'h3FFF, "R2");
    run_frame("R4");

    // R7 two static pulses; the second is not captured
    do_conv(14'h0AAA, 14'h1234, "R2");
    do_conv(14'h3333, 14'h0F0F, "R7");
    sck_to(1'b1); sck_to(1'b0);
    chk_state("R10");
    do_conv(14'h0001, 14'h2001, "R10");
    run_frame("R7");

    // R7 three static pulses
    do_conv(14'h1111, 14'h2222, "R2");
    do_conv(14'h0000, 14'h0000, "R7");
    do_conv(14'h0000, 14'h0000, "R7");
    sck_to(1'b1);
    chk_state("R10");
    do_conv(14'h3000, 14'h0003, "R10");
    run_frame("R7");

    // R9 static high, five pulses to sleep, R11 pulses ignored
    do_conv(14'h2AAA, 14'h1555, "R2");
    sck_to(1'b1);
    do_conv(14'h0123, 14'h0321, "R9");
    for (int k = 0; k < 4; k++) do_conv(14'(k * 77), 14'(k * 91), "R8");
    sck_to(1'b0);
    do_conv(14'h3EEE, 14'h3DDD, "R11");
    chk_state("R11");
    sck_to(1'b1);
    chk_state("R11");
    chk(sdo_oe == 1'b0, "R11", int'(sdo_oe), 0);
    do_conv(14'h0777, 14'h0888, "R11");
    run_frame("R11");

    // R9 edges between pulses restart the count
    for (int k = 0; k < 3; k++) begin
      do_conv(14'(k + 5), 14'(k + 9), "R9");
      sck_to(~sck);
    end

    for (int it = 0; it < 150; it++) begin
      int r = int'($urandom % 8);
      logic [W-1:0] a = W'($urandom), b = W'($urandom);
      if (r < 5) begin
        sck_to(~sck);
        do_conv(a, b, "R2");
        if (m_live) run_frame("R4");
      end else begin
        int n = 1 + int'($urandom % 5);
        if ($urandom % 2) sck_to(~sck);
        for (int k = 0; k < n; k++) do_conv(W'($urandom), W'($urandom), "R8");
        if (m_mode == 2 && ($urandom % 2)) begin
          sck_to(1'b0); sck_to(1'b1);
          chk_state("R11");
        end
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule